// File: doc/BRIEF.md
# Two-Way Set-Associative Byte Cache Controller

This block sits between a byte-wide requester and a word-wide main memory. It keeps two lines per set and picks the set from the middle bits of the address. It tracks recency with one bit per set and can run in write-back or write-through mode.

A disable input sends every access straight to memory. The cached state is left untouched while the cache is off. Two maintenance commands are provided:
- a flush, which copies every modified line to memory and then invalidates the whole cache;
- a plain invalidate, which discards all lines without any memory traffic.

The requester holds `req_i` with a stable address, direction and data until `ready_o` pulses for one cycle. Memory requests follow the same rule: a request is held until `mem_ack_i` pulses, and read data is taken in the acknowledge cycle. A line is one memory word. Memory is addressed by block number and takes byte enables for partial writes.

Top module: `assoc2_cache`

## Requirements
- R1: With the defaults, address bits [1:0] select the byte within the 4-byte line and bits [9:2] select one of 256 sets. Bits [23:10] are the tag. Byte n of a line travels on data bits [8n+7:8n]. `mem_addr_o` carries address bits [23:2]. The set width is a parameter; with 13 set bits the tag is 9 bits wide.
- R2: An access hits when either way of the indexed set is valid and holds a matching tag. A read hit raises `ready_o` with the byte in the cycle after the request is accepted. It causes no memory traffic.
- R3: Each set has one use bit, and any hit marks the referenced way as most recent. On a miss the victim is the first invalid way, trying way 0 before way 1. If both ways are valid, the victim is the way that is not most recent.
- R4: A read miss issues one full-line memory read at the block address and installs the line. The access then completes with the requested byte.
- R5: In write-back mode (`wb_mode_i`=1), a write hit updates only the cached byte and marks the line modified. No memory access occurs.
- R6: A victim line that is valid and modified is written to memory before the refill. The write uses the victim's own block address and byte enable 4'b1111. A clean victim is never written.
- R7: In write-through mode (`wb_mode_i`=0), every write issues one memory write of the byte, with a byte enable that has a single bit set at the offset. A write hit also updates the cached copy. A write miss allocates no line.
- R8: In write-back mode a write miss allocates the line. It reads the block, merges the byte into the cached copy and writes nothing to memory.
- R9: While `cache_off_i`=1, reads and writes go to memory directly. Tags, valid bits, modified bits, data and use bits are left unchanged.
- R10: `flush_i` writes every valid modified line back to memory and invalidates every line. `ready_o` pulses when the walk over all sets ends.
- R11: `inval_i` invalidates every line without any memory write and acknowledges with `ready_o` at once.
- R12: `mem_req_o` is low after reset and while idle. Once raised, it stays high with a stable address until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cache_off_i | input | 1 | Bypass the cache for all accesses |
| wb_mode_i | input | 1 | 1 = write-back, 0 = write-through |
| req_i | input | 1 | Access request, held until ready_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (24) | Byte address |
| wdata_i | input | 8 | Write byte |
| flush_i | input | 1 | Write back modified lines, then invalidate all |
| inval_i | input | 1 | Invalidate all lines without write-back |
| ready_o | output | 1 | Access or command complete |
| rdata_o | output | 8 | Read byte, valid with ready_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | ADDR_W-2 (22) | Memory block address |
| mem_be_o | output | 4 | Memory byte enables |
| mem_wdata_o | output | 32 | Memory write line |
| mem_rdata_i | input | 32 | Memory read line |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |

## Verification
Faults in the internal state show up at the memory port. A stale valid bit or a wrong tag turns an expected miss into a hit, so the memory read that should have followed is missing. This is visible when the access completes, a few cycles after the request. A wrong use bit or modified bit changes which block the next conflicting miss evicts, and whether that block is written back. This shows only on the following miss to the same set, as a wrong write-back address or an extra or missing memory write. Bypass and flush faults surface later still: cached bytes come back changed when the cache is re-enabled, or memory contents are wrong once the flush finishes.

// File: rtl/cache_pkg.sv
package cache_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_REFILL,
    ST_BYPASS,
    ST_FLUSH
  } state_e;
endpackage

// File: rtl/c2w_way.sv
module c2w_way #(
  parameter int SET_BITS = 8,
  parameter int TAG_W    = 14,
  parameter int LINE_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_BITS-1:0] rd_idx_i,
  output logic                vld_o,
  output logic                dirty_o,
  output logic [TAG_W-1:0]    tag_o,
  output logic [LINE_W-1:0]   data_o,
  input  logic                wr_en_i,
  input  logic [SET_BITS-1:0] wr_idx_i,
  input  logic                wr_vld_i,
  input  logic                wr_dirty_i,
  input  logic [TAG_W-1:0]    wr_tag_i,
  input  logic [LINE_W-1:0]   wr_data_i,
  input  logic                clr_all_i
);
  localparam int NSETS = 1 << SET_BITS;

  logic              vld_q   [NSETS];
  logic              dirty_q [NSETS];
  logic [TAG_W-1:0]  tag_q   [NSETS];
  logic [LINE_W-1:0] data_q  [NSETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSETS; i++) begin
        vld_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
      end
    end else if (clr_all_i) begin
      for (int i = 0; i < NSETS; i++) begin
        vld_q[i]   <= 1'b0;
        dirty_q[i] <= 1'b0;
      end
    end else if (wr_en_i) begin
      vld_q[wr_idx_i]   <= wr_vld_i;
      dirty_q[wr_idx_i] <= wr_dirty_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[wr_idx_i]  <= wr_tag_i;
      data_q[wr_idx_i] <= wr_data_i;
    end
  end

  assign vld_o   = vld_q[rd_idx_i];
  assign dirty_o = dirty_q[rd_idx_i];
  assign tag_o   = tag_q[rd_idx_i];
  assign data_o  = data_q[rd_idx_i];

  AST_CLR_ALL_EMPTIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_all_i |=> !vld_q[$past(rd_idx_i)]) else $error("clear-all left a valid line"); // R11
endmodule

// File: rtl/c2w_use.sv
module c2w_use #(
  parameter int SET_BITS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_BITS-1:0] rd_idx_i,
  output logic                mru_o,
  input  logic                upd_en_i,
  input  logic [SET_BITS-1:0] upd_idx_i,
  input  logic                upd_way_i
);
  localparam int NSETS = 1 << SET_BITS;

  logic use_q [NSETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NSETS; i++) use_q[i] <= 1'b0;
    end else if (upd_en_i) begin
      use_q[upd_idx_i] <= upd_way_i;
    end
  end

  assign mru_o = use_q[rd_idx_i];

  AST_USE_FOLLOWS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> (use_q[$past(upd_idx_i)] == $past(upd_way_i))) else $error("use bit not updated"); // R3
endmodule

// File: rtl/assoc2_cache.sv
module assoc2_cache
  import cache_pkg::*;
#(
  parameter  int ADDR_W   = 24,
  parameter  int SET_BITS = 8,
  parameter  int OFF_W    = 2,
  localparam int LINE_B   = 1 << OFF_W,
  localparam int LINE_W   = BYTE_W * LINE_B,
  localparam int TAG_W    = ADDR_W - SET_BITS - OFF_W,
  localparam int BLK_W    = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cache_off_i,
  input  logic              wb_mode_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              flush_i,
  input  logic              inval_i,
  output logic              ready_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BLK_W-1:0]  mem_addr_o,
  output logic [LINE_B-1:0] mem_be_o,
  output logic [LINE_W-1:0] mem_wdata_o,
  input  logic [LINE_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  state_e              st_q, st_d;
  logic [ADDR_W-1:0]   addr_q;
  logic                we_q;
  logic [BYTE_W-1:0]   wdata_q;
  logic                victim_q, victim_d;
  logic [SET_BITS-1:0] fidx_q;
  logic                fway_q;
  logic                accept, victim_ld, fl_start, fl_adv;

  logic [SET_BITS-1:0] idx_w, look_idx;
  logic [TAG_W-1:0]    tag_w;
  logic [OFF_W-1:0]    off_w;

  assign idx_w    = addr_q[OFF_W +: SET_BITS];
  assign tag_w    = addr_q[ADDR_W-1 -: TAG_W];
  assign off_w    = addr_q[OFF_W-1:0];
  assign look_idx = (st_q == ST_FLUSH) ? fidx_q : idx_w;

  logic              vld_r   [2];
  logic              dirty_r [2];
  logic [TAG_W-1:0]  tag_r   [2];
  logic [LINE_W-1:0] data_r  [2];
  logic [1:0]        hit_w, wr_en;
  logic [SET_BITS-1:0] wr_idx;
  logic              wr_vld, wr_dirty, clr_all;
  logic [TAG_W-1:0]  wr_tag;
  logic [LINE_W-1:0] wr_data;
  logic              hit, hit_way, mru, upd_en;

  for (genvar w = 0; w < 2; w++) begin : g_way
    c2w_way #(.SET_BITS(SET_BITS), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_way (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .rd_idx_i  (look_idx),
      .vld_o     (vld_r[w]),
      .dirty_o   (dirty_r[w]),
      .tag_o     (tag_r[w]),
      .data_o    (data_r[w]),
      .wr_en_i   (wr_en[w]),
      .wr_idx_i  (wr_idx),
      .wr_vld_i  (wr_vld),
      .wr_dirty_i(wr_dirty),
      .wr_tag_i  (wr_tag),
      .wr_data_i (wr_data),
      .clr_all_i (clr_all)
    );
    assign hit_w[w] = vld_r[w] && (tag_r[w] == tag_w);
  end

  assign hit     = |hit_w;
  assign hit_way = hit_w[1];

  c2w_use #(.SET_BITS(SET_BITS)) u_use (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_idx_i (idx_w),
    .mru_o    (mru),
    .upd_en_i (upd_en),
    .upd_idx_i(idx_w),
    .upd_way_i(hit_way)
  );

  function automatic logic [BYTE_W-1:0] pick_byte(logic [LINE_W-1:0] l, logic [OFF_W-1:0] o);
    return l[o*BYTE_W +: BYTE_W];
  endfunction

  function automatic logic [LINE_W-1:0] merge_byte(logic [LINE_W-1:0] l, logic [OFF_W-1:0] o,
                                                   logic [BYTE_W-1:0] b);
    logic [LINE_W-1:0] r;
    r = l;
    r[o*BYTE_W +: BYTE_W] = b;
    return r;
  endfunction

  // invalid way first, else the way not most recently used
  always_comb begin
    if (!vld_r[0])      victim_d = 1'b0;
    else if (!vld_r[1]) victim_d = 1'b1;
    else                victim_d = ~mru;
  end

  logic fl_dirty, fl_last;
  assign fl_dirty = vld_r[fway_q] && dirty_r[fway_q];
  assign fl_last  = (fidx_q == '1) && fway_q;

  always_comb begin
    st_d        = st_q;
    ready_o     = 1'b0;
    rdata_o     = '0;
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = {tag_w, idx_w};
    mem_be_o    = '1;
    mem_wdata_o = data_r[victim_q];
    wr_en       = '0;
    wr_idx      = idx_w;
    wr_vld      = 1'b1;
    wr_dirty    = 1'b0;
    wr_tag      = tag_w;
    wr_data     = mem_rdata_i;
    clr_all     = 1'b0;
    upd_en      = 1'b0;
    accept      = 1'b0;
    victim_ld   = 1'b0;
    fl_start    = 1'b0;
    fl_adv      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (flush_i) begin
          fl_start = 1'b1;
          st_d     = ST_FLUSH;
        end else if (inval_i) begin
          clr_all = 1'b1;
          ready_o = 1'b1;
        end else if (req_i) begin
          accept = 1'b1;
          st_d   = cache_off_i ? ST_BYPASS : ST_LOOKUP;
        end
      end
      ST_LOOKUP: begin
        if (hit) begin
          upd_en = 1'b1;
          if (!we_q) begin
            ready_o = 1'b1;
            rdata_o = pick_byte(data_r[hit_way], off_w);
            st_d    = ST_IDLE;
          end else begin
            wr_en[hit_way] = 1'b1;
            wr_data        = merge_byte(data_r[hit_way], off_w, wdata_q);
            wr_dirty       = wb_mode_i | dirty_r[hit_way];
            if (wb_mode_i) begin
              ready_o = 1'b1;
              st_d    = ST_IDLE;
            end else begin
              st_d = ST_BYPASS;
            end
          end
        end else if (we_q && !wb_mode_i) begin
          st_d = ST_BYPASS;
        end else begin
          victim_ld = 1'b1;
          st_d = (vld_r[victim_d] && dirty_r[victim_d]) ? ST_WBACK : ST_REFILL;
        end
      end
      ST_WBACK: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        mem_addr_o = {tag_r[victim_q], idx_w};
        if (mem_ack_i) st_d = ST_REFILL;
      end
      ST_REFILL: begin
        mem_req_o = 1'b1;
        if (mem_ack_i) begin
          wr_en[victim_q] = 1'b1;
          st_d            = ST_LOOKUP;
        end
      end
      ST_BYPASS: begin
        mem_req_o   = 1'b1;
        mem_we_o    = we_q;
        mem_be_o    = we_q ? (LINE_B'(1) << off_w) : '1;
        mem_wdata_o = {LINE_B{wdata_q}};
        if (mem_ack_i) begin
          ready_o = 1'b1;
          rdata_o = pick_byte(mem_rdata_i, off_w);
          st_d    = ST_IDLE;
        end
      end
      ST_FLUSH: begin
        mem_we_o    = 1'b1;
        mem_req_o   = fl_dirty;
        mem_addr_o  = {tag_r[fway_q], fidx_q};
        mem_wdata_o = data_r[fway_q];
        wr_idx      = fidx_q;
        wr_tag      = tag_r[fway_q];
        wr_data     = data_r[fway_q];
        wr_vld      = 1'b0;
        if (!fl_dirty || mem_ack_i) begin
          wr_en[fway_q] = 1'b1;
          fl_adv        = 1'b1;
          if (fl_last) begin
            ready_o = 1'b1;
            st_d    = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      we_q     <= 1'b0;
      wdata_q  <= '0;
      victim_q <= 1'b0;
      fidx_q   <= '0;
      fway_q   <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        addr_q  <= addr_i;
        we_q    <= we_i;
        wdata_q <= wdata_i;
      end
      if (victim_ld) victim_q <= victim_d;
      if (fl_start) begin
        fidx_q <= '0;
        fway_q <= 1'b0;
      end else if (fl_adv) begin
        fway_q <= ~fway_q;
        if (fway_q) fidx_q <= fidx_q + 1'b1;
      end
    end
  end

  AST_SINGLE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP) |-> ($countones(hit_w) <= 1)) else $error("block in both ways"); // R2
  AST_READ_HIT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && hit && !we_q) |-> (ready_o && !mem_req_o)) else $error("read hit stalled"); // R2
  AST_WT_GOES_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_LOOKUP && we_q && !wb_mode_i) |=> (st_q == ST_BYPASS)) else $error("write-through skipped memory"); // R7
  AST_FILL_THEN_LOOK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_REFILL && mem_ack_i) |=> (st_q == ST_LOOKUP && hit)) else $error("refill did not install line"); // R4
  AST_MEM_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o))) else $error("memory request dropped"); // R12
endmodule

// File: tb/test_assoc2_cache.sv
`timescale 1ns/1ps
module test_assoc2_cache;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_off = 1'b0, wb_mode = 1'b1;
  logic        req = 1'b0, we = 1'b0, flush = 1'b0, inval = 1'b0;
  logic [23:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        ready;
  logic [7:0]  rdata;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [21:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata = '0;

  int checks = 0, fails = 0;
  int n_rd = 0, n_wr = 0, lat = 0;
  logic [21:0] last_wr_blk;
  logic [3:0]  last_wr_be;
  logic [7:0]  mem_b [int];

  always #10 clk = ~clk;

  assoc2_cache i_assoc2_cache (
    .clk_i(clk), .rst_ni(rst_n), .cache_off_i(cache_off), .wb_mode_i(wb_mode),
    .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .flush_i(flush),
    .inval_i(inval), .ready_o(ready), .rdata_o(rdata), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_be_o(mem_be),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  function automatic logic [7:0] init_b(logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] mem_byte(logic [23:0] a);
    return mem_b.exists(int'(a)) ? mem_b[int'(a)] : init_b(a);
  endfunction

  // memory model: ack two cycles after request is seen
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (lat == 1) begin
        lat     <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          n_wr        <= n_wr + 1;
          last_wr_blk <= mem_addr;
          last_wr_be  <= mem_be;
          for (int i = 0; i < 4; i++)
            if (mem_be[i]) mem_b[int'({mem_addr, 2'(i)})] = mem_wdata[8*i +: 8];
        end else begin
          n_rd <= n_rd + 1;
          for (int i = 0; i < 4; i++) mem_rdata[8*i +: 8] <= mem_byte({mem_addr, 2'(i)});
        end
      end else begin
        lat <= lat + 1;
      end
    end
  end

  task automatic check(input string req_tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  task automatic wait_ready();
    do @(negedge clk); while (!ready);
  endtask

  task automatic access(input logic w, input logic [23:0] a, input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d;
    wait_ready();
    q = rdata;
    req = 1'b0;
  endtask

  localparam logic [23:0] A = 24'h000104, B = 24'h001104, C = 24'h002104;
  localparam logic [23:0] D = 24'h003104, E = 24'h004208;
  logic [7:0] q;
  int r0, w0;

  task automatic snap();
    r0 = n_rd; w0 = n_wr;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R12", "mem_req after reset", mem_req, 1'b0);
    check("R12", "ready after reset", ready, 1'b0);
  endtask

  task automatic t_read_miss_hit();
    snap();
    access(1'b0, A + 1, 8'h00, q);
    check("R4", "read miss data", q, init_b(A + 1));
    check("R4", "read miss one memory read", n_rd - r0, 1);
    check("R1", "refill block address", mem_addr, A[23:2]);
    snap();
    access(1'b0, A + 2, 8'h00, q);
    check("R2", "read hit data", q, init_b(A + 2));
    check("R2", "read hit no memory", (n_rd - r0) + (n_wr - w0), 0);
  endtask

  task automatic t_wb_write_hit();
    snap();
    access(1'b1, A + 3, 8'hC3, q);
    check("R5", "write-back hit no memory", (n_rd - r0) + (n_wr - w0), 0);
    access(1'b0, A + 3, 8'h00, q);
    check("R5", "write-back hit readback", q, 8'hC3);
    check("R5", "memory untouched", mem_byte(A + 3), init_b(A + 3));
  endtask

  task automatic t_replace();
    snap();
    access(1'b0, B, 8'h00, q);          // fills way 1 (invalid first)
    check("R3", "second block fills empty way, no write", n_wr - w0, 0);
    access(1'b0, A, 8'h00, q);          // A most recent
    snap();
    access(1'b0, C, 8'h00, q);          // evicts B (clean)
    check("R6", "clean victim not written", n_wr - w0, 0);
    snap();
    access(1'b0, A + 1, 8'h00, q);
    check("R3", "recent block kept", n_rd - r0, 0);
    access(1'b0, B, 8'h00, q);          // evicts C
    access(1'b1, B, 8'h3B, q);          // B dirty
    access(1'b0, A, 8'h00, q);          // A most recent
    snap();
    access(1'b0, C, 8'h00, q);          // evicts dirty B
    check("R6", "dirty victim written once", n_wr - w0, 1);
    check("R6", "dirty victim address", last_wr_blk, B[23:2]);
    check("R6", "dirty victim full enables", last_wr_be, 4'b1111);
    check("R6", "victim byte reached memory", mem_byte(B), 8'h3B);
    check("R6", "write-back then refill", n_rd - r0, 1);
    snap();
    access(1'b0, B, 8'h00, q);          // evicts dirty A
    check("R6", "second dirty victim address", last_wr_blk, A[23:2]);
    check("R6", "refetched written byte", q, 8'h3B);
    check("R6", "modified byte of A in memory", mem_byte(A + 3), 8'hC3);
  endtask

  task automatic t_write_through();
    wb_mode = 1'b0;
    snap();
    access(1'b1, B + 1, 8'h77, q);
    check("R7", "write-through hit one write", n_wr - w0, 1);
    check("R7", "write-through byte enable", last_wr_be, 4'b0010);
    check("R7", "write-through memory byte", mem_byte(B + 1), 8'h77);
    snap();
    access(1'b0, B + 1, 8'h00, q);
    check("R7", "cached copy updated", q, 8'h77);
    check("R7", "cached copy read without memory", n_rd - r0, 0);
    snap();
    access(1'b1, D + 2, 8'h99, q);
    check("R7", "write miss enables", last_wr_be, 4'b0100);
    check("R7", "write miss no fetch", n_rd - r0, 0);
    snap();
    access(1'b0, D + 2, 8'h00, q);
    check("R7", "write miss not allocated", n_rd - r0, 1);
    check("R7", "write miss data in memory", q, 8'h99);
    wb_mode = 1'b1;
  endtask

  task automatic t_wb_write_miss();
    snap();
    access(1'b1, E, 8'h5E, q);
    check("R8", "allocate fetch", n_rd - r0, 1);
    check("R8", "allocate no write", n_wr - w0, 0);
    snap();
    access(1'b0, E, 8'h00, q);
    check("R8", "merged byte hit", q, 8'h5E);
    check("R8", "merged byte no memory", n_rd - r0, 0);
    check("R8", "memory keeps old byte", mem_byte(E), init_b(E));
  endtask

  task automatic t_disabled();
    cache_off = 1'b1;
    snap();
    access(1'b1, E + 1, 8'hAB, q);
    check("R9", "bypass write to memory", n_wr - w0, 1);
    check("R9", "bypass write enables", last_wr_be, 4'b0010);
    access(1'b0, E, 8'h00, q);
    check("R9", "bypass read from memory", q, init_b(E));
    cache_off = 1'b0;
    snap();
    access(1'b0, E, 8'h00, q);
    check("R9", "cached line kept", q, 8'h5E);
    access(1'b0, E + 1, 8'h00, q);
    check("R9", "cached byte not updated by bypass", q, init_b(E + 1));
    check("R9", "no memory after re-enable", n_rd - r0, 0);
  endtask

  task automatic t_flush();
    snap();
    @(negedge clk);
    flush = 1'b1;
    wait_ready();
    flush = 1'b0;
    check("R10", "flush writes only modified line", n_wr - w0, 1);
    check("R10", "flushed byte in memory", mem_byte(E), 8'h5E);
    snap();
    access(1'b0, E, 8'h00, q);
    check("R10", "miss after flush", n_rd - r0, 1);
    check("R10", "data after flush", q, 8'h5E);
  endtask

  task automatic t_inval();
    access(1'b0, B, 8'h00, q);
    access(1'b1, B + 2, 8'h12, q);
    snap();
    @(negedge clk);
    inval = 1'b1;
    wait_ready();
    inval = 1'b0;
    check("R11", "invalidate no write", n_wr - w0, 0);
    access(1'b0, B + 2, 8'h00, q);
    check("R11", "line gone after invalidate", n_rd - r0, 1);
    check("R11", "modified byte discarded", q, init_b(B + 2));
  endtask

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_read_miss_hit();
    t_wb_write_hit();
    t_replace();
    t_write_through();
    t_wb_write_miss();
    t_disabled();
    t_flush();
    t_inval();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule